// File: doc/BRIEF.md
# Stream Test-Sequence Receive Checker

This block watches a data stream that carries a per-word valid qualifier and decides whether the received words form an unbroken test sequence. The sequence is either pseudo-random, produced by a linear feedback shift register (LFSR), or an incrementing counter. Each word is judged against the word that came before it. The checker therefore locks onto whatever the transmitter sends, with no shared seed and no start marker. In counter mode it can accept any one of a set of programmable increments instead of only +1.

While the enable input is high, the block counts valid words, keeps the most recent word, and raises a sticky error flag once any word breaks the sequence. A result-valid flag reports when the error flag carries meaning, which is once at least two words have arrived. Pulling enable low clears the whole checker, ready for a new run.

When the user data word is wider than the test sequence, the transmitter repeats the narrow sequence across the wide word. An optional registered front end confirms that every copy agrees with the low copy. If any copy disagrees, the front end passes on an all-ones word, which the checker then flags.

Top module: `stream_seq_checker`

## Requirements
- R1: While `en_i` is low, `count_o`, `sample_o`, `err_o` and `res_valid_o` are all zero one clock later. Valid words that arrive in that time have no effect on them.
- R2: With `en_i` high, `count_o` (32 bits) rises by one for every valid sequence word.
- R3: `sample_o` holds the most recent valid sequence word received while enabled.
- R4: `res_valid_o` stays low until a second valid word has arrived since enable rose. It rises two clock edges after that second word reaches the checker. `err_o` is never high while `res_valid_o` is low.
- R5: With `mode_i` = 0 (LFSR), a word passes if it equals `{prev[W-2:0], fb}`. Here `fb` is the XOR of the previous word's bits at the polynomial's tap positions. For W = 16 the taps are bits 15, 13, 12 and 10.
- R6: With `mode_i` = 1 and `USE_STEPS` = 1, a word passes if it equals the previous word plus any one of the `NSTEP` step values, modulo 2^W. Steps are packed in `steps_i`, with step j at bits [j*W +: W], and are read as two's complement.
- R7: With `mode_i` = 1 and `USE_STEPS` = 0, only an increment of +1 (modulo 2^W) passes.
- R8: `err_o` is sticky. After a failing word it stays high until `en_i` goes low, and later correct words do not clear it.
- R9: When `DATA_W` > `SEQ_W`, data bit i must equal bit i mod `SEQ_W` for every upper bit. If any copy disagrees, the sequence word becomes all ones. The front end adds one cycle of latency to both the word and its valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Checker enable; low clears all checker state |
| mode_i | input | 1 | 0 = LFSR sequence, 1 = counter sequence |
| steps_i | input | NSTEP*SEQ_W | Packed signed counter increments |
| in_valid_i | input | 1 | Input word qualifier |
| in_data_i | input | DATA_W | Input data word |
| err_o | output | 1 | Sticky sequence error |
| res_valid_o | output | 1 | Error flag is meaningful |
| count_o | output | 32 | Valid words received since enable |
| sample_o | output | SEQ_W | Last valid sequence word |

## Verification
On every cycle, the assertions check the following: the clear that follows a low enable, the one-per-word count step, the sample capture of each sequence word, the sticky hold of the error flag, and that an error or a valid result never appears before two words have been counted. Only the bench scenarios can show the rest. These are whether a given word should pass in LFSR mode, under each programmed step, or under the fixed +1 of the configuration without steps, including wrap-around through zero. They also cover whether a replica mismatch in the wide word really yields an all-ones word and an error.

// File: rtl/seq_chk_pkg.sv
// Shared constants and helpers for the stream sequence checker.
// Assumes sequence widths between 2 and 64 bits.
package seq_chk_pkg;

    localparam int CNT_W = 32;

    // Feedback tap mask (bit k set = bit k feeds the XOR) for a maximal-length LFSR
    function automatic logic [63:0] lfsr_taps(input int w);
        case (w)
            8:       return 64'h0000_0000_0000_00B8;
            16:      return 64'h0000_0000_0000_B400;
            24:      return 64'h0000_0000_00E1_0000;
            32:      return 64'h0000_0000_8020_0003;
            default: return (64'd3 << (w - 2));
        endcase
    endfunction

endpackage

// File: rtl/seq_recover.sv
// Front end that recovers a narrow sequence replicated across a wide word.
// Every upper bit i must equal bit (i mod SEQ_W). On any disagreement the
// output word is forced to all ones. One register stage; valid follows.
// Assumes DATA_W > SEQ_W (the top bypasses this module otherwise).
module seq_recover #(
    parameter int DATA_W = 32,
    parameter int SEQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [SEQ_W-1:0]  out_word
);

    logic replica_bad;

    // Compare each upper bit against its counterpart in the low copy
    always_comb begin
        replica_bad = 1'b0;
        for (int i = SEQ_W; i < DATA_W; i++) begin
            replica_bad = replica_bad | (in_data[i] ^ in_data[i % SEQ_W]);
        end
    end

    // Register the recovered word and its qualifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            out_word  <= replica_bad ? '1 : in_data[SEQ_W-1:0];
        end
    end

endmodule

// File: rtl/seq_predict.sv
// Combinational mismatch vector between a received word and what its
// predecessor implies. LFSR mode: one shift step of the previous word.
// Counter mode: any of NSTEP programmable steps (USE_STEPS=1) or +1.
// A zero vector means the word passes.
module seq_predict #(
    parameter int SEQ_W     = 16,
    parameter int NSTEP     = 4,
    parameter bit USE_STEPS = 1'b1
) (
    input  logic [SEQ_W-1:0]       prev,
    input  logic [SEQ_W-1:0]       cur,
    input  logic                   mode,
    input  logic [NSTEP*SEQ_W-1:0] steps,
    output logic [SEQ_W-1:0]       diff
);

    import seq_chk_pkg::*;

    localparam logic [63:0]      TAPS_FULL = lfsr_taps(SEQ_W);
    localparam logic [SEQ_W-1:0] TAPS      = TAPS_FULL[SEQ_W-1:0];

    logic [SEQ_W-1:0] lfsr_exp;
    logic [SEQ_W-1:0] cnt_diff;

    // Next LFSR value: shift left, feedback into bit 0
    always_comb begin
        lfsr_exp = {prev[SEQ_W-2:0], ^(prev & TAPS)};
    end

    if (USE_STEPS) begin : g_steps
        logic [NSTEP-1:0] hit;
        for (genvar j = 0; j < NSTEP; j++) begin : g_hit
            assign hit[j] = (cur == SEQ_W'(prev + steps[j*SEQ_W +: SEQ_W]));
        end
        assign cnt_diff = (|hit) ? '0 : (cur ^ SEQ_W'(prev + steps[SEQ_W-1:0]));
    end else begin : g_unit
        assign cnt_diff = cur ^ SEQ_W'(prev + SEQ_W'(1));
    end

    // Select the mismatch of the active pattern
    always_comb begin
        diff = mode ? cnt_diff : (cur ^ lfsr_exp);
    end

endmodule

// File: rtl/seq_tracker.sv
// Verification state of the checker: word count, last word (also the
// predecessor for prediction), sticky mismatch accumulation and the
// registered error/result-valid outputs. Enable low clears everything.
module seq_tracker #(
    parameter int SEQ_W     = 16,
    parameter int NSTEP     = 4,
    parameter bit USE_STEPS = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   mode,
    input  logic [NSTEP*SEQ_W-1:0] steps,
    input  logic                   vld,
    input  logic [SEQ_W-1:0]       word,
    output logic                   err_o,
    output logic                   res_valid_o,
    output logic [31:0]            count_o,
    output logic [SEQ_W-1:0]       sample_o
);

    logic [SEQ_W-1:0] last_word;
    logic             have_one;
    logic             judged;
    logic [SEQ_W-1:0] err_acc;
    logic [31:0]      count_q;
    logic             err_q;
    logic             judged_q;
    logic [SEQ_W-1:0] diff;

    seq_predict #(
        .SEQ_W    (SEQ_W),
        .NSTEP    (NSTEP),
        .USE_STEPS(USE_STEPS)
    ) u_predict (
        .prev (last_word),
        .cur  (word),
        .mode (mode),
        .steps(steps),
        .diff (diff)
    );

    // Track words, accumulate mismatches, and register the summary flags
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            last_word <= '0;
            have_one  <= 1'b0;
            judged    <= 1'b0;
            err_acc   <= '0;
            count_q   <= '0;
            err_q     <= 1'b0;
            judged_q  <= 1'b0;
        end else begin
            if (vld) begin
                count_q   <= count_q + 32'd1;
                last_word <= word;
                have_one  <= 1'b1;
                if (have_one) begin
                    judged  <= 1'b1;
                    err_acc <= err_acc | diff;
                end
            end
            err_q    <= |err_acc;
            judged_q <= judged;
        end
    end

    assign err_o       = err_q;
    assign res_valid_o = judged_q;
    assign count_o     = count_q;
    assign sample_o    = last_word;

endmodule

// File: rtl/stream_seq_checker.sv
// Top of the stream test-sequence receive checker. Optionally recovers a
// replicated narrow sequence from a wide word, then checks it word by word.
// Assumes DATA_W >= SEQ_W and SEQ_W >= 2.
module stream_seq_checker #(
    parameter int DATA_W    = 32,
    parameter int SEQ_W     = 16,
    parameter int NSTEP     = 4,
    parameter bit USE_STEPS = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic                   mode_i,
    input  logic [NSTEP*SEQ_W-1:0] steps_i,
    input  logic                   in_valid_i,
    input  logic [DATA_W-1:0]      in_data_i,
    output logic                   err_o,
    output logic                   res_valid_o,
    output logic [31:0]            count_o,
    output logic [SEQ_W-1:0]       sample_o
);

    logic             seq_vld;
    logic [SEQ_W-1:0] seq_word;

    if (DATA_W > SEQ_W) begin : g_recover
        seq_recover #(
            .DATA_W(DATA_W),
            .SEQ_W (SEQ_W)
        ) u_recover (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid_i),
            .in_data  (in_data_i),
            .out_valid(seq_vld),
            .out_word (seq_word)
        );
    end else begin : g_direct
        assign seq_vld  = in_valid_i;
        assign seq_word = in_data_i[SEQ_W-1:0];
    end

    seq_tracker #(
        .SEQ_W    (SEQ_W),
        .NSTEP    (NSTEP),
        .USE_STEPS(USE_STEPS)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_i),
        .mode       (mode_i),
        .steps      (steps_i),
        .vld        (seq_vld),
        .word       (seq_word),
        .err_o      (err_o),
        .res_valid_o(res_valid_o),
        .count_o    (count_o),
        .sample_o   (sample_o)
    );

endmodule

// File: rtl/stream_seq_checker_sva.sv
// Property checker for stream_seq_checker, attached by bind below.
module stream_seq_checker_sva #(
    parameter int SEQ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             seq_vld,
    input logic [SEQ_W-1:0] seq_word,
    input logic             err,
    input logic             rv,
    input logic [31:0]      count,
    input logic [SEQ_W-1:0] sample
);

    // R1: disabled checker clears all outputs
    a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == 32'd0 && sample == '0 && !err && !rv));

    // R2: one count per enabled valid word
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && seq_vld) |=> (count == $past(count) + 32'd1));

    // R3: sample captures the sequence word
    a_r3_sample_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (en && seq_vld) |=> (sample == $past(seq_word)));

    // R4: a valid result needs two counted words
    a_r4_valid_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
        rv |-> (count >= 32'd2));

    // R4: error only with a valid result
    a_r4_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rv);

    // R8: error stays set while enabled
    a_r8_sticky_error: assert property (@(posedge clk) disable iff (!rst_n)
        (en && err) |=> err);

endmodule

bind stream_seq_checker stream_seq_checker_sva #(.SEQ_W(SEQ_W)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_i),
    .seq_vld (seq_vld),
    .seq_word(seq_word),
    .err     (err_o),
    .rv      (res_valid_o),
    .count   (count_o),
    .sample  (sample_o)
);

// File: tb/tb_stream_seq_checker.sv
module tb_stream_seq_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        mode = 1'b0;
    logic [63:0] steps;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;

    logic        err, rv, err_p, rv_p;
    logic [31:0] count, count_p;
    logic [15:0] sample, sample_p;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        int          due;
        logic [31:0] a;
        logic [31:0] b;
        string       tag;
    } item_t;

    item_t qc[$];
    item_t qr[$];

    // model state
    logic [15:0] m_prev = '0;
    logic        m_have = 1'b0;
    logic [31:0] m_cnt = '0;
    logic        m_err = 1'b0;
    logic        m_rv = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign steps = {16'h0100, 16'h0005, 16'hFFFD, 16'h0001};

    stream_seq_checker dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode), .steps_i(steps),
        .in_valid_i(in_valid), .in_data_i(in_data),
        .err_o(err), .res_valid_o(rv), .count_o(count), .sample_o(sample)
    );

    stream_seq_checker #(.DATA_W(16), .SEQ_W(16), .NSTEP(4), .USE_STEPS(1'b0)) dut_p (
        .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode), .steps_i(steps),
        .in_valid_i(in_valid), .in_data_i(in_data[15:0]),
        .err_o(err_p), .res_valid_o(rv_p), .count_o(count_p), .sample_o(sample_p)
    );

    function automatic logic [15:0] lfsr_nx(input logic [15:0] p);
        return {p[14:0], p[15] ^ p[13] ^ p[12] ^ p[10]};
    endfunction

    function automatic logic word_ok(input logic [15:0] p, input logic [15:0] c, input logic md);
        if (!md) return c == lfsr_nx(p);
        for (int j = 0; j < 4; j++)
            if (c == 16'(p + steps[j*16 +: 16])) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] rep(input logic [15:0] x);
        return {x, x};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Driver: one valid word, expected results queued
    task automatic send(input logic [31:0] d, input string tag);
        logic [15:0] rec;
        item_t ic, ir;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        rec = (d[31:16] == d[15:0]) ? d[15:0] : 16'hFFFF;
        if (en) begin
            m_cnt++;
            if (m_have) begin
                m_rv = 1'b1;
                if (!word_ok(m_prev, rec, mode)) m_err = 1'b1;
            end
            m_prev = rec;
            m_have = 1'b1;
        end
        ic.due = cyc + 2; ic.a = m_cnt; ic.b = {16'h0, m_prev}; ic.tag = tag;
        ir.due = cyc + 3; ir.a = {31'h0, m_err}; ir.b = {31'h0, m_rv}; ir.tag = tag;
        qc.push_back(ic);
        qr.push_back(ir);
    endtask

    task automatic gap(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain;
        gap(1);
        wait (qc.size() == 0 && qr.size() == 0);
        gap(1);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        en = v;
        if (!v) begin
            m_prev = '0; m_have = 1'b0; m_cnt = '0; m_err = 1'b0; m_rv = 1'b0;
        end
    endtask

    // Monitor: pop and compare when results are due
    always @(negedge clk) begin
        if (qc.size() > 0 && qc[0].due == cyc) begin
            item_t it;
            it = qc.pop_front();
            check(count == it.a, {"R2 count ", it.tag}, count, it.a);
            check({16'h0, sample} == it.b, {"R3 sample ", it.tag}, {16'h0, sample}, it.b);
        end
        if (qr.size() > 0 && qr[0].due == cyc) begin
            item_t it;
            it = qr.pop_front();
            check({31'h0, err} == it.a, {"R8 error ", it.tag}, {31'h0, err}, it.a);
            check({31'h0, rv} == it.b, {"R4 result valid ", it.tag}, {31'h0, rv}, it.b);
        end
    end

    task automatic check_idle(input string tag);
        check(count == 0 && sample == 0 && !err && !rv, tag,
              {count[15:0], sample}, 32'h0);
    endtask

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        gap(2);
        check_idle("R1 reset state");

        // R1: words ignored while disabled
        send(rep(16'h1234), "R1 disabled word");
        send(rep(16'h1235), "R1 disabled word");
        drain();
        check_idle("R1 disabled stays clear");

        // R5: LFSR mode, good run, then a corrupted word, then good again
        set_en(1'b1);
        mode = 1'b0;
        w = 16'h1234;
        for (int k = 0; k < 6; k++) begin
            send(rep(w), "R5 lfsr good");
            w = lfsr_nx(w);
            if (k == 2) gap(2);
        end
        drain();
        check(!err && rv, "R5 lfsr run passes", {30'h0, err, rv}, 32'h1);
        send(rep(w ^ 16'h0001), "R5 lfsr bad");
        w = lfsr_nx(w ^ 16'h0001);
        for (int k = 0; k < 3; k++) begin
            send(rep(w), "R8 good after bad");
            w = lfsr_nx(w);
        end
        drain();
        check(err, "R8 error held after good words", {31'h0, err}, 32'h1);

        set_en(1'b0);
        gap(3);
        check_idle("R1 R8 disable clears");

        // R6: counter mode with every step and wrap-around
        set_en(1'b1);
        mode = 1'b1;
        send(rep(16'hFFFA), "R4 first word");
        gap(4);
        check(!rv && count == 1, "R4 one word not valid", {31'h0, rv}, 32'h0);
        send(rep(16'hFFFF), "R6 step +5");
        send(rep(16'h0000), "R6 step +1 wrap");
        send(rep(16'hFFFD), "R6 step -3 wrap");
        send(rep(16'h00FD), "R6 step +0x100");
        send(rep(16'h0102), "R6 step +5");
        drain();
        check(!err && rv, "R6 all steps pass", {30'h0, err, rv}, 32'h1);
        send(rep(16'h0104), "R6 step +2 rejected");
        drain();
        check(err, "R6 illegal step flagged", {31'h0, err}, 32'h1);

        // R7: the +1-only configuration rejects +5 that the stepped one accepts
        set_en(1'b0);
        gap(2);
        set_en(1'b1);
        send(rep(16'h0010), "R7 seq");
        send(rep(16'h0011), "R7 seq");
        send(rep(16'h0012), "R7 seq");
        drain();
        check(!err_p && rv_p, "R7 plain +1 passes", {30'h0, err_p, rv_p}, 32'h1);
        check(count_p == 3 && sample_p == 16'h0012, "R7 plain count/sample",
              {count_p[15:0], sample_p}, 32'h0003_0012);
        send(rep(16'h0017), "R7 step +5");
        drain();
        check(err_p, "R7 plain rejects +5", {31'h0, err_p}, 32'h1);
        check(!err, "R6 stepped accepts +5", {31'h0, err}, 32'h0);

        // R9: replica mismatch forces all ones
        set_en(1'b0);
        gap(2);
        set_en(1'b1);
        send(rep(16'h0020), "R9 good");
        send({16'h0031, 16'h0021}, "R9 replica mismatch");
        drain();
        check(sample == 16'hFFFF, "R9 all-ones word", {16'h0, sample}, 32'h0000_FFFF);
        check(err, "R9 mismatch flagged", {31'h0, err}, 32'h1);

        set_en(1'b0);
        gap(3);
        check_idle("R1 final clear");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule